// File: doc/BRIEF.md
# Parallel Window Rank Computer

The block takes a complete window of nine unsigned 8-bit pixels in one cycle, together with a valid strobe. It gives each pixel its rank, which is its place in the window sorted from smallest to largest. The same result also gives the smallest, middle and largest pixel values. Every pixel is compared with every other pixel in a single matrix of comparators. Each pixel then adds up its own comparison bits. The design never builds a sorted copy of the values: the three order statistics are picked out of the window by rank.

The block is pipelined over two register stages and accepts a new window on every clock. A nonlinear image filter, such as a median, min or max filter or a rank-based remapping, connects it after the circuit that extracts the window from the pixel stream. When two pixels are equal, the lower index is treated as the smaller one. Because of this rule the ranks are always a permutation of 0 to 8, so the selection logic never finds a missing rank or a rank that appears twice.

Top module: `window_rank_top`

## Requirements
- R1: Pixel j arrives on in_pix[8j+7:8j], and its rank leaves on out_rank[4j+3:4j] as a 4-bit unsigned number. The rank is the count of other pixels i that hold a smaller value, plus those that hold an equal value and have i < j.
- R2: For every valid result, the nine rank fields hold each of the values 0 through 8 exactly once.
- R3: out_min carries the value of the pixel whose rank is 0, which is the smallest value in the window.
- R4: out_med carries the value of the pixel whose rank is 4, which is the median of the window.
- R5: out_max carries the value of the pixel whose rank is 8, which is the largest value in the window.
- R6: out_valid rises exactly two clock edges after a window is presented with in_valid high, and the outputs then belong to that window.
- R7: Windows presented on consecutive cycles come out on consecutive cycles, each with its own correct result.
- R8: While out_valid is low, out_rank, out_min, out_med and out_max keep the result of the last valid window. Pixel data presented with in_valid low has no effect on them.
- R9: While reset is held, out_valid is 0 and out_rank, out_min, out_med and out_max are all zero.
- R10: When all nine pixels are equal, pixel j receives rank j.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | The window on in_pix is valid this cycle |
| in_pix | input | 72 | Nine 8-bit pixels, pixel j at bits 8j+7:8j |
| out_valid | output | 1 | The outputs carry a new result |
| out_rank | output | 36 | Nine 4-bit ranks, rank of pixel j at bits 4j+3:4j |
| out_min | output | 8 | Smallest pixel value of the window |
| out_med | output | 8 | Median pixel value of the window |
| out_max | output | 8 | Largest pixel value of the window |

## Verification
Two events can fall in the same cycle:
- a result leaves stage two while the next window is captured into stage one;
- a gap in the valid strobe, while garbage pixels are on the input, sits right beside the result of the last valid window.

The stimulus produces both. It mixes back-to-back random windows with random gaps during which in_pix carries random data. Every output cycle is judged against a bench model of the window presented two edges earlier. Every gap cycle is judged against the last valid result, so a capture that leaks through, or a result that is dropped, shows up as a mismatch. The directed windows are:
- all pixels equal;
- values in ascending and in descending order;
- duplicate values at the ends of the range;
- a single outlier.

These exercise the tie rule and the rank-0, rank-4 and rank-8 picks.

// File: rtl/wrank_pkg.sv
package wrank_pkg;
  localparam int unsigned DEF_N = 9;
  localparam int unsigned DEF_W = 8;

  function automatic int unsigned rank_width(input int unsigned n);
    return (n < 3) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/wrank_cmp_matrix.sv
module wrank_cmp_matrix #(
  parameter int unsigned N = 9,
  parameter int unsigned W = 8
) (
  input  logic [N*W-1:0] pix,
  output logic [N*N-1:0] below
);
  // below[j*N+i] = pixel i counts as lower than pixel j
  for (genvar j = 0; j < N; j++) begin : g_row
    for (genvar i = 0; i < N; i++) begin : g_col
      if (i == j) begin : g_diag
        assign below[j*N+i] = 1'b0;
      end else if (i < j) begin : g_lo
        // equal values: lower index wins the tie
        assign below[j*N+i] = (pix[i*W +: W] <= pix[j*W +: W]);
      end else begin : g_hi
        assign below[j*N+i] = (pix[i*W +: W] < pix[j*W +: W]);
      end
    end
  end
endmodule

// File: rtl/wrank_rank_sum.sv
module wrank_rank_sum #(
  parameter int unsigned N  = 9,
  parameter int unsigned RW = 4
) (
  input  logic [N*N-1:0]  below,
  output logic [N*RW-1:0] rank
);
  for (genvar j = 0; j < N; j++) begin : g_elem
    logic [RW-1:0] acc;
    always_comb begin
      acc = '0;
      for (int i = 0; i < N; i++) begin
        acc = acc + RW'(below[j*N+i]);
      end
    end
    assign rank[j*RW +: RW] = acc;
  end
endmodule

// File: rtl/wrank_pick.sv
module wrank_pick #(
  parameter int unsigned N  = 9,
  parameter int unsigned W  = 8,
  parameter int unsigned RW = 4,
  parameter int unsigned K  = 0
) (
  input  logic [N*W-1:0]  pix,
  input  logic [N*RW-1:0] rank,
  output logic [W-1:0]    val
);
  // ranks form a permutation, so exactly one term is non-zero
  always_comb begin
    val = '0;
    for (int j = 0; j < N; j++) begin
      if (rank[j*RW +: RW] == RW'(K)) begin
        val = val | pix[j*W +: W];
      end
    end
  end
endmodule

// File: rtl/window_rank_top.sv
module window_rank_top
  import wrank_pkg::*;
#(
  parameter int unsigned N = DEF_N,
  parameter int unsigned W = DEF_W,
  localparam int unsigned RW  = rank_width(N),
  localparam int unsigned MID = (N - 1) / 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [N*W-1:0] in_pix,
  output logic          out_valid,
  output logic [N*RW-1:0] out_rank,
  output logic [W-1:0]  out_min,
  output logic [W-1:0]  out_med,
  output logic [W-1:0]  out_max
);
  localparam int unsigned NSEL = 3;
  localparam int unsigned SEL_RANK [NSEL] = '{0, MID, N - 1};

  // reset: asserted at once, released after two clock edges
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  // stage 1: comparison matrix
  logic [N*N-1:0] below_c;
  logic           s1_valid, s1_valid_d;
  logic [N*W-1:0] s1_pix, s1_pix_d;
  logic [N*N-1:0] s1_below, s1_below_d;

  wrank_cmp_matrix #(.N(N), .W(W)) u_cmp (
    .pix   (in_pix),
    .below (below_c)
  );

  always_comb begin
    s1_valid_d = in_valid;
    s1_pix_d   = in_valid ? in_pix  : s1_pix;
    s1_below_d = in_valid ? below_c : s1_below;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      s1_valid <= 1'b0;
      s1_pix   <= '0;
      s1_below <= '0;
    end else begin
      s1_valid <= s1_valid_d;
      s1_pix   <= s1_pix_d;
      s1_below <= s1_below_d;
    end
  end

  // stage 2: rank sums and order statistics
  logic [N*RW-1:0] rank_c;
  logic [W-1:0]    sel_c [NSEL];

  wrank_rank_sum #(.N(N), .RW(RW)) u_sum (
    .below (s1_below),
    .rank  (rank_c)
  );

  for (genvar s = 0; s < NSEL; s++) begin : g_sel
    wrank_pick #(.N(N), .W(W), .RW(RW), .K(SEL_RANK[s])) u_pick (
      .pix  (s1_pix),
      .rank (rank_c),
      .val  (sel_c[s])
    );
  end

  logic            s2_valid_d;
  logic [N*RW-1:0] s2_rank_d;
  logic [W-1:0]    s2_min_d, s2_med_d, s2_max_d;

  always_comb begin
    s2_valid_d = s1_valid;
    s2_rank_d  = s1_valid ? rank_c   : out_rank;
    s2_min_d   = s1_valid ? sel_c[0] : out_min;
    s2_med_d   = s1_valid ? sel_c[1] : out_med;
    s2_max_d   = s1_valid ? sel_c[2] : out_max;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      out_valid <= 1'b0;
      out_rank  <= '0;
      out_min   <= '0;
      out_med   <= '0;
      out_max   <= '0;
    end else begin
      out_valid <= s2_valid_d;
      out_rank  <= s2_rank_d;
      out_min   <= s2_min_d;
      out_med   <= s2_med_d;
      out_max   <= s2_max_d;
    end
  end
endmodule

// File: rtl/window_rank_chk.sv
module window_rank_chk #(
  parameter int unsigned N  = 9,
  parameter int unsigned W  = 8,
  parameter int unsigned RW = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            out_valid,
  input logic [N*RW-1:0] out_rank,
  input logic [W-1:0]    out_min,
  input logic [W-1:0]    out_med,
  input logic [W-1:0]    out_max
);
  // R6
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##2 out_valid);

  // R6
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> ##2 !out_valid);

  for (genvar k = 0; k < N; k++) begin : g_perm
    logic [N-1:0] hit;
    for (genvar j = 0; j < N; j++) begin : g_hit
      assign hit[j] = (out_rank[j*RW +: RW] == RW'(k));
    end
    // R2
    perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ($countones(hit) == 1));
  end

  // R3
  order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_min <= out_med) && (out_med <= out_max));

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_rank) && $stable(out_min) &&
                   $stable(out_med) && $stable(out_max));
endmodule

bind window_rank_top window_rank_chk #(.N(N), .W(W), .RW(RW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .in_valid  (in_valid),
  .out_valid (out_valid),
  .out_rank  (out_rank),
  .out_min   (out_min),
  .out_med   (out_med),
  .out_max   (out_max)
);

// File: tb/window_rank_top_tb.sv
module window_rank_top_tb;
  localparam int N  = 9;
  localparam int W  = 8;
  localparam int RW = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic            rst_n;
  logic            in_valid;
  logic [N*W-1:0]  in_pix;
  logic            out_valid;
  logic [N*RW-1:0] out_rank;
  logic [W-1:0]    out_min, out_med, out_max;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  window_rank_top u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pix(in_pix),
    .out_valid(out_valid), .out_rank(out_rank),
    .out_min(out_min), .out_med(out_med), .out_max(out_max)
  );

  function automatic logic [N*RW-1:0] ref_rank(input logic [N*W-1:0] p);
    logic [N*RW-1:0] r;
    for (int j = 0; j < N; j++) begin
      int cnt = 0;
      for (int i = 0; i < N; i++) begin
        if (i != j) begin
          if (p[i*W +: W] < p[j*W +: W]) cnt++;
          else if (p[i*W +: W] == p[j*W +: W] && i < j) cnt++;
        end
      end
      r[j*RW +: RW] = cnt[RW-1:0];
    end
    return r;
  endfunction

  function automatic logic [W-1:0] ref_kth(input logic [N*W-1:0] p, input int k);
    logic [W-1:0] a [N];
    for (int i = 0; i < N; i++) a[i] = p[i*W +: W];
    for (int i = 1; i < N; i++) begin
      for (int m = i; m > 0; m--) begin
        if (a[m] < a[m-1]) begin
          logic [W-1:0] t = a[m];
          a[m] = a[m-1];
          a[m-1] = t;
        end
      end
    end
    return a[k];
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // model of the two-cycle pipeline
  logic            d1_v = 1'b0, d2_v = 1'b0, have_last = 1'b0;
  logic [N*W-1:0]  d1_p = '0, d2_p = '0, last_p = '0;
  string           d1_t = "R1", d2_t = "R1";

  task automatic step(input logic v, input logic [N*W-1:0] p, input string tag);
    @(negedge clk);
    if (d2_v) begin
      logic [N-1:0] seen = '0;
      check("R6,R7 out_valid", 64'(out_valid), 64'd1);
      check({tag, " ranks"}, 64'(out_rank), 64'(ref_rank(d2_p)));
      for (int j = 0; j < N; j++) begin
        if (out_rank[j*RW +: RW] < RW'(N)) seen[out_rank[j*RW +: RW]] = 1'b1;
      end
      check("R2 permutation", 64'(seen), {{(64-N){1'b0}}, {N{1'b1}}});
      check("R3 min", 64'(out_min), 64'(ref_kth(d2_p, 0)));
      check("R4 median", 64'(out_med), 64'(ref_kth(d2_p, (N-1)/2)));
      check("R5 max", 64'(out_max), 64'(ref_kth(d2_p, N-1)));
      last_p    = d2_p;
      have_last = 1'b1;
    end else begin
      check("R6 out_valid low", 64'(out_valid), 64'd0);
      if (have_last) begin
        check("R8 hold ranks", 64'(out_rank), 64'(ref_rank(last_p)));
        check("R8 hold min", 64'(out_min), 64'(ref_kth(last_p, 0)));
        check("R8 hold max", 64'(out_max), 64'(ref_kth(last_p, N-1)));
      end
    end
    d2_v = d1_v; d2_p = d1_p; d2_t = d1_t;
    d1_v = v;    d1_p = p;    d1_t = tag;
    in_valid = v;
    in_pix   = p;
  endtask

  function automatic logic [N*W-1:0] rnd_win();
    logic [N*W-1:0] p;
    for (int i = 0; i < N; i++) p[i*W +: W] = W'($urandom);
    return p;
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_pix   = '0;
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 valid in reset", 64'(out_valid), 64'd0);
    check("R9 rank in reset", 64'(out_rank), 64'd0);
    check("R9 min/med/max in reset", {40'd0, out_min, out_med, out_max}, 64'd0);
    rst_n = 1'b1;
    repeat (4) step(1'b0, rnd_win(), "R1");

    // directed corners
    step(1'b1, {N{8'd77}}, "R10");
    begin
      logic [N*W-1:0] asc, dsc;
      for (int i = 0; i < N; i++) begin
        asc[i*W +: W] = W'(i * 20);
        dsc[i*W +: W] = W'(250 - i * 25);
      end
      step(1'b1, asc, "R1");
      step(1'b1, dsc, "R1");
    end
    step(1'b1, {8'd255, 8'd0, 8'd255, 8'd0, 8'd128, 8'd0, 8'd255, 8'd0, 8'd255}, "R1");
    step(1'b1, {8'd5, 8'd5, 8'd5, 8'd5, 8'd200, 8'd5, 8'd5, 8'd5, 8'd5}, "R1");
    step(1'b0, rnd_win(), "R1");
    step(1'b0, rnd_win(), "R1");
    step(1'b0, rnd_win(), "R1");
    step(1'b1, {8'd3, 8'd3, 8'd1, 8'd1, 8'd2, 8'd2, 8'd0, 8'd0, 8'd4}, "R1");

    // random stream with gaps; values folded to a small range for ties
    for (int n = 0; n < 400; n++) begin
      logic [N*W-1:0] p = rnd_win();
      if (n % 3 == 1) begin
        for (int i = 0; i < N; i++) p[i*W +: W] = p[i*W +: W] & 8'h07;
      end
      step(($urandom % 4) != 0, p, "R1");
    end
    repeat (4) step(1'b0, rnd_win(), "R1");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule